// File: doc/BRIEF.md
# Load/Store Data Alignment Formatter

This block sits between a 32-bit core and a 32-bit data memory that numbers its bytes big-endian. The lowest address of a word sits in the most significant byte lane. On a store it takes an address, an access size, right-justified store data and a byte-swap flag. It then drives the memory with a word-aligned address, the data placed in the right lanes, and per-lane byte enables. On a load it takes the word the memory returns one cycle after the beat. From that word it extracts the addressed byte, halfword or word, optionally swaps the byte order, and widens the value to 32 bits with zeros or with its sign bit.

An access whose bytes stay inside one memory word costs a single beat and adds no bubble. A halfword or word that runs past the end of a word is split into two beats at consecutive word addresses. The block keeps the request context internally, so the core presents it only once. The block raises `stall` during the cycle of the second beat, and it ignores any request presented in that cycle. For a split load, the bytes of both returned words are merged into one result.

Top module: `ls_align_fmt`

## Requirements
- R1: `req_size` encodes 2'b00 byte, 2'b01 halfword, 2'b10 or 2'b11 word. On a store, `mem_be` bit 3 enables the lane of word offset 0 (bits 31:24) and bit 0 enables offset 3 (bits 7:0). Across its beats the store enables exactly the lanes of its bytes. Loads drive `mem_be` to zero.
- R2: Store data is taken from the low-order bytes of `req_wdata`. Without swapping, its most significant used byte goes to the lowest address. Every disabled lane carries zero data, and memory bytes outside the access are unchanged.
- R3: A load with `req_sext`=0 returns the addressed bytes, lowest address most significant, zero-extended to 32 bits.
- R4: A load with `req_sext`=1 replicates bit 7 (byte) or bit 15 (halfword) of the result into all upper bits.
- R5: With `req_rev`=1 a load reverses the order of its own bytes before extension. A halfword swaps its two bytes, a word reverses all four, and a byte is unchanged.
- R6: With `req_rev`=1 a store writes its bytes in reversed order, so the least significant byte of the data lands at the lowest address.
- R7: An access that does not cross a word boundary (this includes a halfword at offset 1) issues one beat in its request cycle, never raises `stall`, and a load result appears with `ld_valid` in the following cycle.
- R8: An access with offset plus size greater than four issues its first beat in the request cycle. Its second beat goes to the word address plus 4 in the next cycle, with `stall` high for exactly that one cycle. A split load's result appears two cycles after the request.
- R9: A request presented while `stall` is high is ignored: it issues no beat and leaves no state behind.
- R10: A new request is accepted in the same cycle a previous load result is delivered, and both results are correct.
- R11: After reset `stall`, `mem_en` (with `req_valid` low) and `ld_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents an access this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size code |
| req_sext | input | 1 | Sign-extend a load result |
| req_rev | input | 1 | Reverse byte order of the access |
| req_wdata | input | 32 | Store data, right-justified |
| stall | output | 1 | Second beat of a split access in progress |
| mem_en | output | 1 | Memory beat issued |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_be | output | 4 | Write byte enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word, valid the cycle after a read beat |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Formatted load result |

## Verification
The bench checks every access against a byte-array model, so the key corner cases are the ones where a lane or shift error stays hidden inside aligned words. These are words at offsets 1 to 3, halfwords at offset 3 and the non-crossing halfword at offset 1. A design that shifts by the wrong amount, or wraps instead of moving to the next word, would corrupt neighbouring bytes or merge the wrong word. Combinations of sign extension and byte swap show whether extension uses the bit after the swap; a design that extends first would copy the wrong sign bit. A junk request during the stall cycle and back-to-back loads expose a design that accepts work while busy or reuses a load context that a newer request has overwritten.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;
  localparam int unsigned WIN_W = 2 * WORD_W;

  // number of bytes touched by a size code
  function automatic logic [2:0] size_nbytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic crosses_word(input logic [1:0] off, input logic [2:0] n);
    return ({1'b0, off} + n) > 3'd4;
  endfunction

  // keep only the low n bytes
  function automatic logic [WORD_W-1:0] keep_low(input logic [WORD_W-1:0] d, input logic [2:0] n);
    case (n)
      3'd1:    return {24'h0, d[7:0]};
      3'd2:    return {16'h0, d[15:0]};
      default: return d;
    endcase
  endfunction

  // reverse the order of the low n bytes
  function automatic logic [WORD_W-1:0] swap_low(input logic [WORD_W-1:0] d, input logic [2:0] n);
    case (n)
      3'd1:    return {24'h0, d[7:0]};
      3'd2:    return {16'h0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  // lane slot of the last byte inside an 8-byte window, counted from the right
  function automatic logic [3:0] tail_slot(input logic [1:0] off, input logic [2:0] n);
    return 4'd8 - {2'b00, off} - {1'b0, n};
  endfunction

  // store data placed in a two-word window (upper word = first beat)
  function automatic logic [WIN_W-1:0] place_store(input logic [WORD_W-1:0] d, input logic [1:0] off,
                                                   input logic [2:0] n, input logic rev);
    logic [WORD_W-1:0] v;
    v = rev ? swap_low(d, n) : keep_low(d, n);
    return {32'h0, v} << {tail_slot(off, n), 3'b000};
  endfunction

  function automatic logic [2*LANES-1:0] place_enables(input logic [1:0] off, input logic [2:0] n);
    logic [2*LANES-1:0] m;
    case (n)
      3'd1:    m = 8'h01;
      3'd2:    m = 8'h03;
      default: m = 8'h0F;
    endcase
    return m << tail_slot(off, n);
  endfunction

  // select, optionally swap, then extend a load from a two-word window
  function automatic logic [WORD_W-1:0] format_load(input logic [WIN_W-1:0] win, input logic [1:0] off,
                                                    input logic [2:0] n, input logic sext, input logic rev);
    logic [WIN_W-1:0] s;
    logic [WORD_W-1:0] v;
    s = win << {off, 3'b000};
    case (n)
      3'd1:    v = {24'h0, s[63:56]};
      3'd2:    v = {16'h0, s[63:48]};
      default: v = s[63:32];
    endcase
    if (rev) v = swap_low(v, n);
    if (sext) begin
      case (n)
        3'd1:    v = {{24{v[7]}}, v[7:0]};
        3'd2:    v = {{16{v[15]}}, v[15:0]};
        default: v = v;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/ls_store_place.sv
module ls_store_place
  import ls_align_pkg::*;
(
  input  logic [WORD_W-1:0]   wdata,
  input  logic [1:0]          off,
  input  logic [2:0]          nbytes,
  input  logic                rev,
  output logic [WIN_W-1:0]    win_data,
  output logic [2*LANES-1:0]  win_be
);
  always_comb begin
    win_data = place_store(wdata, off, nbytes, rev);
    win_be   = place_enables(off, nbytes);
  end
endmodule

// File: rtl/ls_load_merge.sv
module ls_load_merge
  import ls_align_pkg::*;
(
  input  logic [WORD_W-1:0] rdata,
  input  logic [WORD_W-1:0] first_word,
  input  logic              split,
  input  logic [1:0]        off,
  input  logic [2:0]        nbytes,
  input  logic              sext,
  input  logic              rev,
  output logic [WORD_W-1:0] result
);
  logic [WIN_W-1:0] window;
  always_comb begin
    window = split ? {first_word, rdata} : {rdata, {WORD_W{1'b0}}};
    result = format_load(window, off, nbytes, sext, rev);
  end
endmodule

// File: rtl/ls_beat_ctrl.sv
module ls_beat_ctrl
  import ls_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2:0]          req_n,
  input  logic                req_sext,
  input  logic                req_rev,
  input  logic [WIN_W-1:0]    win_data,
  input  logic [2*LANES-1:0]  win_be,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [LANES-1:0]    mem_be,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic                stall,
  output logic                ld_valid,
  output logic [1:0]          lf_off,
  output logic [2:0]          lf_n,
  output logic                lf_sext,
  output logic                lf_rev,
  output logic                lf_split,
  output logic [WORD_W-1:0]   first_word_q,
  output logic                split_start_w,
  output logic                ld_final_w
);
  logic                second_q;
  logic                ctx_store;
  logic [ADDR_W-1:0]   ctx_addr2;
  logic [LANES-1:0]    ctx_be;
  logic [WORD_W-1:0]   ctx_data;
  logic [1:0]          ctx_off;
  logic [2:0]          ctx_n;
  logic                ctx_sext;
  logic                ctx_rev;
  logic                ld_valid_q;
  logic                accept_w;
  logic [ADDR_W-1:0]   base_w;

  assign base_w        = {req_addr[ADDR_W-1:2], 2'b00};
  assign accept_w      = req_valid && !second_q;
  assign split_start_w = accept_w && crosses_word(req_addr[1:0], req_n);
  assign ld_final_w    = (accept_w && !req_store && !split_start_w) || (second_q && !ctx_store);
  assign stall         = second_q;
  assign ld_valid      = ld_valid_q;

  always_comb begin
    if (second_q) begin
      mem_en    = 1'b1;
      mem_we    = ctx_store;
      mem_addr  = ctx_addr2;
      mem_be    = ctx_store ? ctx_be : '0;
      mem_wdata = ctx_store ? ctx_data : '0;
    end else begin
      mem_en    = req_valid;
      mem_we    = req_valid && req_store;
      mem_addr  = base_w;
      mem_be    = (req_valid && req_store) ? win_be[2*LANES-1:LANES] : '0;
      mem_wdata = (req_valid && req_store) ? win_data[WIN_W-1:WORD_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q     <= 1'b0;
      ctx_store    <= 1'b0;
      ctx_addr2    <= '0;
      ctx_be       <= '0;
      ctx_data     <= '0;
      ctx_off      <= '0;
      ctx_n        <= '0;
      ctx_sext     <= 1'b0;
      ctx_rev      <= 1'b0;
      ld_valid_q   <= 1'b0;
      lf_off       <= '0;
      lf_n         <= '0;
      lf_sext      <= 1'b0;
      lf_rev       <= 1'b0;
      lf_split     <= 1'b0;
      first_word_q <= '0;
    end else begin
      second_q   <= split_start_w;
      ld_valid_q <= ld_final_w;
      if (split_start_w) begin
        ctx_store <= req_store;
        ctx_addr2 <= base_w + ADDR_W'(4);
        ctx_be    <= win_be[LANES-1:0];
        ctx_data  <= win_data[WORD_W-1:0];
        ctx_off   <= req_addr[1:0];
        ctx_n     <= req_n;
        ctx_sext  <= req_sext;
        ctx_rev   <= req_rev;
      end
      if (second_q && !ctx_store) first_word_q <= mem_rdata;
      if (ld_final_w) begin
        if (second_q) begin
          lf_off   <= ctx_off;
          lf_n     <= ctx_n;
          lf_sext  <= ctx_sext;
          lf_rev   <= ctx_rev;
          lf_split <= 1'b1;
        end else begin
          lf_off   <= req_addr[1:0];
          lf_n     <= req_n;
          lf_sext  <= req_sext;
          lf_rev   <= req_rev;
          lf_split <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ls_align_fmt.sv
module ls_align_fmt
  import ls_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_sext,
  input  logic              req_rev,
  input  logic [31:0]       req_wdata,
  output logic              stall,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              ld_valid,
  output logic [31:0]       ld_data
);
  logic [2:0]          req_n;
  logic [WIN_W-1:0]    win_data;
  logic [2*LANES-1:0]  win_be;
  logic [1:0]          lf_off;
  logic [2:0]          lf_n;
  logic                lf_sext;
  logic                lf_rev;
  logic                lf_split;
  logic [WORD_W-1:0]   first_word_q;
  logic                split_start_w;
  logic                ld_final_w;

  assign req_n = size_nbytes(req_size);

  ls_store_place u_place (
    .wdata    (req_wdata),
    .off      (req_addr[1:0]),
    .nbytes   (req_n),
    .rev      (req_rev),
    .win_data (win_data),
    .win_be   (win_be)
  );

  ls_beat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_store     (req_store),
    .req_addr      (req_addr),
    .req_n         (req_n),
    .req_sext      (req_sext),
    .req_rev       (req_rev),
    .win_data      (win_data),
    .win_be        (win_be),
    .mem_rdata     (mem_rdata),
    .mem_en        (mem_en),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .mem_wdata     (mem_wdata),
    .stall         (stall),
    .ld_valid      (ld_valid),
    .lf_off        (lf_off),
    .lf_n          (lf_n),
    .lf_sext       (lf_sext),
    .lf_rev        (lf_rev),
    .lf_split      (lf_split),
    .first_word_q  (first_word_q),
    .split_start_w (split_start_w),
    .ld_final_w    (ld_final_w)
  );

  ls_load_merge u_merge (
    .rdata      (mem_rdata),
    .first_word (first_word_q),
    .split      (lf_split),
    .off        (lf_off),
    .nbytes     (lf_n),
    .sext       (lf_sext),
    .rev        (lf_rev),
    .result     (ld_data)
  );
endmodule

// File: rtl/ls_align_fmt_chk.sv
module ls_align_fmt_chk
  import ls_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        req_size,
  input logic              stall,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              ld_valid,
  input logic              split_start_w,
  input logic              ld_final_w
);
  a_r8_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  a_r8_split_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    split_start_w |=> stall);
  a_r8_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (mem_en && mem_addr == $past(mem_addr) + ADDR_W'(4)));
  a_r7_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ld_final_w |=> ld_valid);
  a_r7_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_en && !mem_we));
  a_r1_single_beat_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !stall && !split_start_w) |-> ($countones(mem_be) == int'(size_nbytes(req_size))));
  a_r1_load_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (mem_be == 4'b0000));
  a_r11_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[1:0] == 2'b00));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    a_r2_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && !mem_be[g]) |-> (mem_wdata[g*BYTE_W +: BYTE_W] == 8'h00));
  end
endmodule

bind ls_align_fmt ls_align_fmt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_size      (req_size),
  .stall         (stall),
  .mem_en        (mem_en),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_be        (mem_be),
  .mem_wdata     (mem_wdata),
  .ld_valid      (ld_valid),
  .split_start_w (split_start_w),
  .ld_final_w    (ld_final_w)
);

// File: tb/ls_align_fmt_tb.sv
module ls_align_fmt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_sext = 1'b0;
  logic        req_rev = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        stall;
  logic        mem_en;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        ld_valid;
  logic [31:0] ld_data;

  int checks = 0;
  int failures = 0;

  logic [7:0] mem_b [64];
  logic [7:0] ref_b [64];
  logic [31:0] rd_q = '0;

  always #2 clk = ~clk;

  ls_align_fmt #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_size(req_size), .req_sext(req_sext), .req_rev(req_rev),
    .req_wdata(req_wdata), .stall(stall), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // simple word memory, read data one cycle after the beat
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_en) begin
      for (int k = 0; k < 4; k++) begin
        if (mem_we && mem_be[3-k]) mem_b[mem_addr[5:2]*4 + k] <= mem_wdata[31-8*k -: 8];
      end
      rd_q <= {mem_b[mem_addr[5:2]*4], mem_b[mem_addr[5:2]*4+1],
               mem_b[mem_addr[5:2]*4+2], mem_b[mem_addr[5:2]*4+3]};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ref_load(input logic [31:0] a, input int n, input bit sx, input bit rv);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = ref_b[(a + i) & 63];
      if (rv) v = v | (32'(b) << (8*i));
      else    v = v | (32'(b) << (8*(n-1-i)));
    end
    if (sx && n == 1) v = {{24{v[7]}}, v[7:0]};
    if (sx && n == 2) v = {{16{v[15]}}, v[15:0]};
    return v;
  endfunction

  task automatic mem_compare(input string req);
    int bad = -1;
    for (int i = 0; i < 64; i++) if (mem_b[i] !== ref_b[i] && bad < 0) bad = i;
    chk(bad < 0, req, (bad < 0) ? 32'h0 : 32'(mem_b[bad]), (bad < 0) ? 32'h0 : 32'(ref_b[bad]));
  endtask

  task automatic access(input bit st, input logic [31:0] a, input logic [1:0] sz, input bit sx,
                        input bit rv, input logic [31:0] wd, input bit junk);
    int n = nb(sz);
    int off = int'(a[1:0]);
    bit cr = (off + n) > 4;
    logic [7:0] be8 = '0;
    logic [31:0] exp_ld;
    string dtag = rv ? "R5" : (sx ? "R4" : "R3");
    for (int i = 0; i < n; i++) be8[7-(off+i)] = 1'b1;
    exp_ld = ref_load(a, n, sx, rv);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = a; req_size = sz;
    req_sext = sx; req_rev = rv; req_wdata = wd;
    #1;
    chk(mem_en && !stall && mem_we == st, "R7", {stall, mem_we, mem_en}, {1'b0, st, 1'b1});
    chk(mem_addr == {a[31:2], 2'b00}, "R7", mem_addr, {a[31:2], 2'b00});
    chk(mem_be == (st ? be8[7:4] : 4'h0), "R1", 32'(mem_be), 32'(st ? be8[7:4] : 4'h0));
    if (st) begin
      for (int i = 0; i < n; i++) ref_b[(a + i) & 63] = rv ? wd[8*i +: 8] : wd[8*(n-1-i) +: 8];
    end
    @(negedge clk);
    if (junk && cr) begin
      req_valid = 1'b1; req_store = $urandom(); req_addr = $urandom(); req_size = 2'($urandom());
      req_wdata = $urandom(); req_sext = $urandom(); req_rev = $urandom();
    end else req_valid = 1'b0;
    #1;
    if (cr) begin
      chk(stall && mem_en && mem_we == st, "R8", {stall, mem_en, mem_we}, {2'b11, st});
      chk(mem_addr == ({a[31:2], 2'b00} + 32'd4), "R8", mem_addr, {a[31:2], 2'b00} + 32'd4);
      chk(mem_be == (st ? be8[3:0] : 4'h0), "R1", 32'(mem_be), 32'(st ? be8[3:0] : 4'h0));
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(!stall && !mem_en, "R9", {stall, mem_en}, 0);
      if (!st) chk(ld_valid && ld_data == exp_ld, {"R8 ", dtag}, ld_data, exp_ld);
    end else begin
      chk(!stall, "R7", stall, 0);
      if (!st) chk(ld_valid && ld_data == exp_ld, {"R7 ", dtag}, ld_data, exp_ld);
    end
    if (st) mem_compare(rv ? "R6" : "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] ea, eb;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin
      mem_b[i] = 8'(i * 37 + 5);
      ref_b[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    #1;
    chk(!stall && !mem_en && !ld_valid, "R11", {stall, mem_en, ld_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!stall && !mem_en && !ld_valid, "R11", {stall, mem_en, ld_valid}, 0);

    // directed corners
    access(1'b0, 32'h0000_0003, 2'b10, 1'b0, 1'b0, 0, 1'b0);          // R8 word off 3
    access(1'b0, 32'h0000_0007, 2'b01, 1'b1, 1'b1, 0, 1'b1);          // R8 R5 half off 3
    access(1'b0, 32'h0000_0009, 2'b01, 1'b1, 1'b0, 0, 1'b0);          // R7 half off 1
    access(1'b1, 32'h0000_0012, 2'b01, 1'b0, 1'b1, 32'hDEAD_81C4, 1'b0); // R6
    access(1'b0, 32'h0000_0012, 2'b01, 1'b1, 1'b0, 0, 1'b0);          // R4 read back 0xFFFFC481
    access(1'b1, 32'h0000_0021, 2'b00, 1'b0, 1'b0, 32'h1234_56F0, 1'b0); // R2 byte
    access(1'b0, 32'h0000_0021, 2'b00, 1'b1, 1'b0, 0, 1'b0);          // R4 0xFFFFFFF0
    access(1'b1, 32'h0000_003E, 2'b10, 1'b0, 1'b0, 32'hA1B2_C3D4, 1'b1); // R9 wrap split store
    access(1'b0, 32'h0000_003D, 2'b10, 1'b0, 1'b1, 0, 1'b1);          // R5 word reverse split

    // R10: back-to-back loads
    ea = ref_load(32'h10, 4, 1'b0, 1'b0);
    eb = ref_load(32'h15, 1, 1'b1, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_addr = 32'h10; req_size = 2'b10; req_sext = 1'b0; req_rev = 1'b0;
    @(negedge clk);
    req_addr = 32'h15; req_size = 2'b00; req_sext = 1'b1;
    #1;
    chk(ld_valid && ld_data == ea && mem_en, "R10", ld_data, ea);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(ld_valid && ld_data == eb, "R10", ld_data, eb);

    // constrained random mix
    for (int t = 0; t < 800; t++) begin
      access($urandom_range(0, 1) == 1, $urandom(), 2'($urandom_range(0, 3)),
             $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom(),
             $urandom_range(0, 1) == 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule